// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block freezes the local time-of-day counter when a precision-timing event packet starts on the wire, one channel for the transmit direction and one for the receive direction. The MAC presents a start-of-frame strobe together with the fields its parser has already extracted. For transmit, that is a single flag saying the frame was marked for stamping. For receive, it is the Ethertype, a UDP flag and destination port, the protocol version nibble and the message code byte. If the channel is enabled and the frame qualifies, the time value present on that cycle is latched and the channel's valid flag rises.

A captured stamp is one-shot. While a channel's valid flag is up, the stored value is frozen and further qualifying frames in that direction pass without a stamp. Software reads the low word and then the high word, and the read strobe of the high word releases the lock. The receive side qualifies frames by message class. One mode accepts version-1 messages over UDP that carry one configured message code. The other accepts every version-2 event message, whether it travels over UDP or directly over Ethernet under a programmable Ethertype filter entry.

Top module: `pkt_tstamp_latch`

## Requirements
- R1: After synchronous reset both valid flags are 0 and both stamp words read 0.
- R2: With `tx_en` set, a cycle with `tx_sof` and `tx_ts_req` both high latches `time_now` of that same cycle. From the next cycle on, `tx_valid` is 1, `tx_stamp_lo` holds time bits 31:0 and `tx_stamp_hi` holds bits 63:32. A `tx_sof` without `tx_ts_req` latches nothing.
- R3: A channel whose enable input is 0 takes no stamp, whatever frames arrive.
- R4: While a channel's valid flag is 1, its stamp words keep their value, and qualifying frames leave both the stamp and the flag unchanged.
- R5: A pulse on a channel's high-word read input clears its valid flag on the following cycle. A frame arriving in that same cycle is not stamped. The next qualifying frame after the release is stamped again.
- R6: `rx_mode` is encoded as 2'b00 off, 2'b01 version-1 over UDP, 2'b10 version-2 events and 2'b11 reserved. In off and reserved modes no receive frame is stamped.
- R7: In mode 2'b01 a receive frame qualifies only when all of these hold: `rx_is_udp` is 1, `rx_udp_dport` equals `msg_match[31:16]`, `rx_ptp_ver` equals 1, and `rx_msg_code` equals `msg_match[7:0]`.
- R8: In mode 2'b10 a UDP frame with `rx_ptp_ver` equal to 2 and `rx_udp_dport` equal to `msg_match[31:16]` qualifies when the low nibble of `rx_msg_code` is below 8. The value of `msg_match[7:0]` plays no part, so path-delay event types 2 and 3 are stamped as well.
- R9: In mode 2'b10 a non-UDP frame with version 2 and an event nibble qualifies only when `etq_en` and `etq_ts` are both 1 and `rx_ethertype` equals `etq_type`. The bench uses 0x88F7.
- R10: In mode 2'b10, frames with a message nibble of 8 or more, or with a version other than 2, are never stamped.
- R11: The two channels are independent. Traffic, enables and high-word reads on one side never change the valid flag or stamp of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current system time |
| tx_en | input | 1 | Transmit stamping enable |
| rx_en | input | 1 | Receive stamping enable |
| rx_mode | input | 2 | Receive class select (see R6) |
| msg_match | input | 32 | UDP event port in [31:16], version-1 code in [7:0] |
| etq_en | input | 1 | Ethertype filter entry enabled |
| etq_ts | input | 1 | Ethertype filter entry requests stamping |
| etq_type | input | 16 | Ethertype value of the filter entry |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_ts_req | input | 1 | Transmit frame marked for stamping |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ethertype | input | 16 | Parsed Ethertype of the receive frame |
| rx_is_udp | input | 1 | Receive frame is UDP |
| rx_udp_dport | input | 16 | Parsed UDP destination port |
| rx_ptp_ver | input | 4 | Parsed timing-protocol version |
| rx_msg_code | input | 8 | Parsed message code; low nibble is the type |
| tx_hi_rd | input | 1 | Read strobe of the transmit high word |
| rx_hi_rd | input | 1 | Read strobe of the receive high word |
| tx_valid | output | 1 | Transmit stamp held |
| tx_stamp_lo | output | 32 | Transmit stamp bits 31:0 |
| tx_stamp_hi | output | 32 | Transmit stamp bits 63:32 |
| rx_valid | output | 1 | Receive stamp held |
| rx_stamp_lo | output | 32 | Receive stamp bits 31:0 |
| rx_stamp_hi | output | 32 | Receive stamp bits 63:32 |

## Verification
The qualifier is combinational and the latch is a single register stage. A frame strobed in cycle N therefore shows up on the valid flag and stamp words after edge N+1, and a high-word read strobed in cycle M has dropped the flag after edge M+1. The bench drives every strobe for exactly one cycle on the falling edge and records the time value it put on `time_now` at that moment. It then checks the outputs one falling edge later, which is the first point where the registered result is visible and before any further stimulus. The receive sweeps walk all sixteen message nibbles across each transport, filter setting and mode. Each trial releases the lock before the next one, so the expected value of every trial stands on its own.

// File: rtl/pts_pkg.sv
package pts_pkg;

    typedef enum logic [1:0] {
        RXM_OFF    = 2'b00,
        RXM_V1_UDP = 2'b01,
        RXM_V2_EVT = 2'b10,
        RXM_RSVD   = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic [15:0] ethertype;
        logic        is_udp;
        logic [15:0] udp_dport;
        logic [3:0]  ver;
        logic [7:0]  code;
    } rx_fields_t;

    typedef struct packed {
        logic [15:0] port;
        logic [7:0]  v1_code;
    } match_cfg_t;

    localparam int MATCH_PORT_LSB = 16;
    localparam int NUM_CH         = 2;
    localparam int CH_TX          = 0;
    localparam int CH_RX          = 1;

    function automatic match_cfg_t unpack_match(input logic [31:0] raw);
        match_cfg_t m;
        m.port    = raw[MATCH_PORT_LSB +: 16];
        m.v1_code = raw[7:0];
        return m;
    endfunction

    function automatic logic is_v2_event(input logic [7:0] code);
        return (code[3:0] < 4'd8);
    endfunction

endpackage

// File: rtl/pts_rx_qual.sv
module pts_rx_qual
    import pts_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  rx_mode_e    mode,
    input  logic [31:0] match_raw,
    input  logic        etq_en,
    input  logic        etq_ts,
    input  logic [15:0] etq_type,
    input  rx_fields_t  fld,
    output logic        qual
);
    match_cfg_t mcfg;
    logic       port_hit;
    logic       l2_hit;
    logic       v1_ok;
    logic       v2_ok;

    always_comb begin
        mcfg     = unpack_match(match_raw);
        port_hit = fld.is_udp && (fld.udp_dport == mcfg.port);
        l2_hit   = !fld.is_udp && etq_en && etq_ts && (fld.ethertype == etq_type);
        v1_ok    = port_hit && (fld.ver == 4'd1) && (fld.code == mcfg.v1_code);
        v2_ok    = (port_hit || l2_hit) && (fld.ver == 4'd2) && is_v2_event(fld.code);
        unique case (mode)
            RXM_V1_UDP: qual = v1_ok;
            RXM_V2_EVT: qual = v2_ok;
            default:    qual = 1'b0;
        endcase
    end

    // R6
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == RXM_OFF || mode == RXM_RSVD) |-> !qual);

    // R10
    general_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (qual && mode == RXM_V2_EVT) |-> (fld.code[3:0] < 4'd8 && fld.ver == 4'd2));

    // R7
    v1_udp_chk: assert property (@(posedge clk) disable iff (rst)
        (qual && mode == RXM_V1_UDP) |-> (fld.is_udp && fld.ver == 4'd1));

endmodule

// File: rtl/pts_channel.sv
module pts_channel #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              evt,
    input  logic [TIME_W-1:0] time_i,
    input  logic              rd_hi,
    output logic              valid_o,
    output logic [TIME_W-1:0] stamp_o
);
    logic              valid_q;
    logic [TIME_W-1:0] stamp_q;
    logic              take;

    assign take    = en && evt && !valid_q;
    assign valid_o = valid_q;
    assign stamp_o = stamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            stamp_q <= '0;
        end else if (rd_hi) begin
            valid_q <= 1'b0;
        end else if (take) begin
            valid_q <= 1'b1;
            stamp_q <= time_i;
        end
    end

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (en && evt && !valid_o && !rd_hi) |=> (valid_o && stamp_o == $past(time_i)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !rd_hi) |=> (valid_o && $stable(stamp_o)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> !valid_o);

    // R3
    disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !valid_o) |=> !valid_o);

endmodule

// File: rtl/pkt_tstamp_latch.sv
module pkt_tstamp_latch
    import pts_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TIME_W-1:0]    time_now,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic [1:0]           rx_mode,
    input  logic [31:0]          msg_match,
    input  logic                 etq_en,
    input  logic                 etq_ts,
    input  logic [15:0]          etq_type,
    input  logic                 tx_sof,
    input  logic                 tx_ts_req,
    input  logic                 rx_sof,
    input  logic [15:0]          rx_ethertype,
    input  logic                 rx_is_udp,
    input  logic [15:0]          rx_udp_dport,
    input  logic [3:0]           rx_ptp_ver,
    input  logic [7:0]           rx_msg_code,
    input  logic                 tx_hi_rd,
    input  logic                 rx_hi_rd,
    output logic                 tx_valid,
    output logic [WORD_W-1:0]    tx_stamp_lo,
    output logic [TIME_W-WORD_W-1:0] tx_stamp_hi,
    output logic                 rx_valid,
    output logic [WORD_W-1:0]    rx_stamp_lo,
    output logic [TIME_W-WORD_W-1:0] rx_stamp_hi
);
    localparam int HI_W = TIME_W - WORD_W;

    rx_fields_t        fld;
    logic              rx_qual;
    logic [NUM_CH-1:0] ch_en;
    logic [NUM_CH-1:0] ch_evt;
    logic [NUM_CH-1:0] ch_rd;
    logic [NUM_CH-1:0] ch_valid;
    logic [TIME_W-1:0] ch_stamp [NUM_CH];

    always_comb begin
        fld.ethertype = rx_ethertype;
        fld.is_udp    = rx_is_udp;
        fld.udp_dport = rx_udp_dport;
        fld.ver       = rx_ptp_ver;
        fld.code      = rx_msg_code;
    end

    pts_rx_qual u_qual (
        .clk       (clk),
        .rst       (rst),
        .mode      (rx_mode_e'(rx_mode)),
        .match_raw (msg_match),
        .etq_en    (etq_en),
        .etq_ts    (etq_ts),
        .etq_type  (etq_type),
        .fld       (fld),
        .qual      (rx_qual)
    );

    assign ch_en[CH_TX]  = tx_en;
    assign ch_en[CH_RX]  = rx_en;
    assign ch_evt[CH_TX] = tx_sof && tx_ts_req;
    assign ch_evt[CH_RX] = rx_sof && rx_qual;
    assign ch_rd[CH_TX]  = tx_hi_rd;
    assign ch_rd[CH_RX]  = rx_hi_rd;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pts_channel #(.TIME_W(TIME_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .en      (ch_en[c]),
            .evt     (ch_evt[c]),
            .time_i  (time_now),
            .rd_hi   (ch_rd[c]),
            .valid_o (ch_valid[c]),
            .stamp_o (ch_stamp[c])
        );
    end

    assign tx_valid    = ch_valid[CH_TX];
    assign rx_valid    = ch_valid[CH_RX];
    assign tx_stamp_lo = ch_stamp[CH_TX][WORD_W-1:0];
    assign tx_stamp_hi = ch_stamp[CH_TX][TIME_W-1 -: HI_W];
    assign rx_stamp_lo = ch_stamp[CH_RX][WORD_W-1:0];
    assign rx_stamp_hi = ch_stamp[CH_RX][TIME_W-1 -: HI_W];

    // R11
    tx_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_hi_rd) |=> (tx_valid && $stable(tx_stamp_lo) && $stable(tx_stamp_hi)));

    // R11
    rx_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !(rx_sof && rx_en)) |=> !rx_valid);

endmodule

// File: tb/pkt_tstamp_latch_bench.sv
`timescale 1ns/1ps
module pkt_tstamp_latch_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_now = 64'd0;
    logic        tx_en = 0, rx_en = 0;
    logic [1:0]  rx_mode = 2'b00;
    logic [31:0] msg_match = 32'd0;
    logic        etq_en = 0, etq_ts = 0;
    logic [15:0] etq_type = 16'h88F7;
    logic        tx_sof = 0, tx_ts_req = 0, rx_sof = 0;
    logic [15:0] rx_ethertype = 16'h0800;
    logic        rx_is_udp = 0;
    logic [15:0] rx_udp_dport = 16'd0;
    logic [3:0]  rx_ptp_ver = 4'd0;
    logic [7:0]  rx_msg_code = 8'd0;
    logic        tx_hi_rd = 0, rx_hi_rd = 0;
    logic        tx_valid, rx_valid;
    logic [31:0] tx_stamp_lo, tx_stamp_hi, rx_stamp_lo, rx_stamp_hi;

    int n_run = 0;
    int n_fail = 0;
    logic finished = 1'b0;
    logic [63:0] tcnt = 64'd1;

    pkt_tstamp_latch u_pkt_tstamp_latch (
        .clk(clk), .rst(rst), .time_now(time_now),
        .tx_en(tx_en), .rx_en(rx_en), .rx_mode(rx_mode), .msg_match(msg_match),
        .etq_en(etq_en), .etq_ts(etq_ts), .etq_type(etq_type),
        .tx_sof(tx_sof), .tx_ts_req(tx_ts_req), .rx_sof(rx_sof),
        .rx_ethertype(rx_ethertype), .rx_is_udp(rx_is_udp), .rx_udp_dport(rx_udp_dport),
        .rx_ptp_ver(rx_ptp_ver), .rx_msg_code(rx_msg_code),
        .tx_hi_rd(tx_hi_rd), .rx_hi_rd(rx_hi_rd),
        .tx_valid(tx_valid), .tx_stamp_lo(tx_stamp_lo), .tx_stamp_hi(tx_stamp_hi),
        .rx_valid(rx_valid), .rx_stamp_lo(rx_stamp_lo), .rx_stamp_hi(rx_stamp_hi)
    );

    always #10 clk = ~clk;

    // distinct, non-trivial words in both halves every cycle
    always @(posedge clk) begin
        tcnt     <= tcnt + 64'd1;
        time_now <= {tcnt[31:0] ^ 32'hC3A5_0000, tcnt[31:0] * 32'd2654435761};
    end

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic release_rx();
        @(negedge clk); rx_hi_rd = 1'b1;
        @(negedge clk); rx_hi_rd = 1'b0;
    endtask

    task automatic release_tx();
        @(negedge clk); tx_hi_rd = 1'b1;
        @(negedge clk); tx_hi_rd = 1'b0;
    endtask

    // one receive frame, checked one cycle later, then lock released
    task automatic rx_trial(input logic exp, input string req);
        logic [63:0] cap;
        @(negedge clk);
        rx_sof = 1'b1;
        cap = time_now;
        @(negedge clk);
        rx_sof = 1'b0;
        check(rx_valid == exp, req, {63'd0, rx_valid}, {63'd0, exp});
        if (exp)
            check({rx_stamp_hi, rx_stamp_lo} == cap, req, {rx_stamp_hi, rx_stamp_lo}, cap);
        if (rx_valid) release_rx();
    endtask

    task automatic set_rx(input logic udp, input logic [15:0] port,
                          input logic [15:0] ety, input logic [3:0] ver,
                          input logic [7:0] code);
        rx_is_udp = udp; rx_udp_dport = port; rx_ethertype = ety;
        rx_ptp_ver = ver; rx_msg_code = code;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] cap;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!tx_valid && !rx_valid, "R1 valid", {62'd0, tx_valid, rx_valid}, 64'd0);
        check({tx_stamp_hi, tx_stamp_lo, rx_stamp_hi, rx_stamp_lo} == 128'd0, "R1 stamps",
              {tx_stamp_hi, tx_stamp_lo}, 64'd0);

        // R2 transmit capture, word split
        tx_en = 1'b1;
        @(negedge clk); tx_sof = 1'b1; tx_ts_req = 1'b1; cap = time_now;
        @(negedge clk); tx_sof = 1'b0; tx_ts_req = 1'b0;
        check(tx_valid, "R2 tx valid", {63'd0, tx_valid}, 64'd1);
        check(tx_stamp_lo == cap[31:0], "R2 tx lo", {32'd0, tx_stamp_lo}, {32'd0, cap[31:0]});
        check(tx_stamp_hi == cap[63:32], "R2 tx hi", {32'd0, tx_stamp_hi}, {32'd0, cap[63:32]});
        held = cap;

        // R4 further frames while locked change nothing
        @(negedge clk); tx_sof = 1'b1; tx_ts_req = 1'b1;
        @(negedge clk); tx_sof = 1'b0; tx_ts_req = 1'b0;
        check(tx_valid && {tx_stamp_hi, tx_stamp_lo} == held, "R4 tx locked",
              {tx_stamp_hi, tx_stamp_lo}, held);

        // R5 release
        release_tx();
        check(!tx_valid, "R5 tx release", {63'd0, tx_valid}, 64'd0);
        check({tx_stamp_hi, tx_stamp_lo} == held, "R5 stamp kept after release",
              {tx_stamp_hi, tx_stamp_lo}, held);

        // R2 sof without request
        @(negedge clk); tx_sof = 1'b1;
        @(negedge clk); tx_sof = 1'b0;
        check(!tx_valid, "R2 tx no request", {63'd0, tx_valid}, 64'd0);

        // R3 disabled channel
        tx_en = 1'b0;
        @(negedge clk); tx_sof = 1'b1; tx_ts_req = 1'b1;
        @(negedge clk); tx_sof = 1'b0; tx_ts_req = 1'b0;
        check(!tx_valid, "R3 tx disabled", {63'd0, tx_valid}, 64'd0);
        tx_en = 1'b1;

        // R5 frame in the same cycle as the read is dropped; next one taken
        @(negedge clk); tx_sof = 1'b1; tx_ts_req = 1'b1; tx_hi_rd = 1'b1;
        @(negedge clk); tx_sof = 1'b0; tx_ts_req = 1'b0; tx_hi_rd = 1'b0;
        check(!tx_valid, "R5 same-cycle read wins", {63'd0, tx_valid}, 64'd0);
        @(negedge clk); tx_sof = 1'b1; tx_ts_req = 1'b1; cap = time_now;
        @(negedge clk); tx_sof = 1'b0; tx_ts_req = 1'b0;
        check(tx_valid && {tx_stamp_hi, tx_stamp_lo} == cap, "R5 recapture",
              {tx_stamp_hi, tx_stamp_lo}, cap);
        held = cap;

        // R10/R8/R9 version-2 sweep; port 319, configured code irrelevant
        rx_en = 1'b1;
        msg_match = {16'd319, 8'h00, 8'h0F};
        rx_mode = 2'b10;
        etq_en = 1'b1; etq_ts = 1'b1;
        for (int n = 0; n < 16; n++) begin
            set_rx(1'b1, 16'd319, 16'h0800, 4'd2, {4'hA, 4'(n)});
            rx_trial(n < 8, "R8 v2 udp nibble sweep");
            set_rx(1'b1, 16'd320, 16'h0800, 4'd2, {4'hA, 4'(n)});
            rx_trial(1'b0, "R8 v2 wrong port");
            set_rx(1'b0, 16'd0, 16'h88F7, 4'd2, 8'(n));
            rx_trial(n < 8, "R9 v2 layer-2 nibble sweep");
            set_rx(1'b1, 16'd319, 16'h0800, 4'd1, 8'(n));
            rx_trial(1'b0, "R10 v2 mode wrong version");
        end
        // R9 filter entry requirements
        set_rx(1'b0, 16'd0, 16'h88F7, 4'd2, 8'h00);
        etq_ts = 1'b0; rx_trial(1'b0, "R9 stamping flag clear");
        etq_ts = 1'b1; etq_en = 1'b0; rx_trial(1'b0, "R9 entry disabled");
        etq_en = 1'b1;
        set_rx(1'b0, 16'd0, 16'h88F8, 4'd2, 8'h00);
        rx_trial(1'b0, "R9 ethertype mismatch");

        // R7 version-1 sweep, match code 3
        rx_mode = 2'b01;
        msg_match = {16'd319, 8'h00, 8'h03};
        for (int n = 0; n < 16; n++) begin
            set_rx(1'b1, 16'd319, 16'h0800, 4'd1, 8'(n));
            rx_trial(n == 3, "R7 v1 code sweep");
        end
        set_rx(1'b1, 16'd319, 16'h0800, 4'd2, 8'h03);
        rx_trial(1'b0, "R7 v1 mode rejects version 2");
        set_rx(1'b0, 16'd319, 16'h88F7, 4'd1, 8'h03);
        rx_trial(1'b0, "R7 v1 mode rejects non-udp");
        set_rx(1'b1, 16'd318, 16'h0800, 4'd1, 8'h03);
        rx_trial(1'b0, "R7 v1 wrong port");
        set_rx(1'b1, 16'd319, 16'h0800, 4'd1, 8'h13);
        rx_trial(1'b0, "R7 v1 upper code bits compared");

        // R6 off and reserved modes
        for (int m = 0; m < 4; m += 3) begin
            rx_mode = 2'(m);
            for (int n = 0; n < 8; n++) begin
                set_rx(1'b1, 16'd319, 16'h0800, 4'd2, 8'(n));
                rx_trial(1'b0, "R6 off or reserved mode");
            end
        end

        // R3 receive disabled
        rx_mode = 2'b10; rx_en = 1'b0;
        set_rx(1'b1, 16'd319, 16'h0800, 4'd2, 8'h00);
        rx_trial(1'b0, "R3 rx disabled");
        rx_en = 1'b1;

        // R11 tx lock survives rx traffic and rx reads
        check(tx_valid && {tx_stamp_hi, tx_stamp_lo} == held, "R11 tx untouched by rx",
              {tx_stamp_hi, tx_stamp_lo}, held);
        // R11 tx read leaves rx lock intact
        @(negedge clk); rx_sof = 1'b1; cap = time_now;
        @(negedge clk); rx_sof = 1'b0; tx_hi_rd = 1'b1;
        @(negedge clk); tx_hi_rd = 1'b0;
        check(!tx_valid, "R11 tx released", {63'd0, tx_valid}, 64'd0);
        check(rx_valid && {rx_stamp_hi, rx_stamp_lo} == cap, "R11 rx kept over tx read",
              {rx_stamp_hi, rx_stamp_lo}, cap);
        // R4 rx locked against later qualifying frame
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
        check(rx_valid && {rx_stamp_hi, rx_stamp_lo} == cap, "R4 rx locked",
              {rx_stamp_hi, rx_stamp_lo}, cap);
        release_rx();
        check(!rx_valid, "R5 rx release", {63'd0, rx_valid}, 64'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule